// File: doc/BRIEF.md
# Seven-Channel Wait/Hold PWM Controller

A register-programmed pulse-width modulator with seven independent channels. Each channel takes one of five source tick-enable inputs and generates a repeating waveform: high for a programmed number of source ticks, then low for another programmed number. Channels 0 to 5 are meant to leave the chip and channel 6 is used internally. Software programs the block through a simple word-addressed write/read bus. Per channel it can pick the source, set the high and low counts, switch to a bypass mode, and gate the counting and the output in separate stages.

Each channel is a small state machine with three states. `CH_IDLE` is held while the channel's counting stage is off. `CH_HIGH` counts high-phase ticks. `CH_LOW` counts low-phase ticks. The transitions are:
- IDLE→HIGH on the first clock with the counting stage on. This transition loads the shadow counts.
- HIGH→LOW on the tick that completes the high phase.
- LOW→HIGH on the tick that completes the low phase. This transition reloads the shadow counts from the registers.
- Any state→IDLE whenever the counting stage is turned off.

Writes to the count registers therefore act only from the next period onward, and no runt pulse can appear.

Top module: `wh_pwm_top`

## Requirements
- R1: After reset every register reads 0 and all seven `pwm_out` bits are 0.
- R2: Registers are at byte offsets 0x00 (select), 0x04 (output stage), 0x08 (count-stage enable), 0x0C (tick-gate enable), 0x10+8n (high count of channel n) and 0x14+8n (low count of channel n). Written bits read back. Unused bits and unmapped offsets read 0, so all-ones writes read 0x0FFFFFFF, 0x00003FFF, 0x7F, 0x7F and 0xFFFF.
- R3: With high count W and low count H, the output of channel n is high for W+1 ticks of its source and then low for H+1 ticks, repeating. With a source ticking every D clocks, this gives high runs of (W+1)·D and low runs of (H+1)·D clock cycles.
- R4: Bits [3n+2:3n] of the select register pick source tick 0..4 for channel n. The values 5, 6 and 7 select no source: the channel freezes at its present level, and it resumes counting when a valid source is selected again.
- R5: Bit 21+n of the select register puts channel n in bypass mode. The output is then the selected gated tick delayed by one clock, and the counts have no effect.
- R6: While bit n of the count-stage enable (0x08) is 0, channel n is held idle with a low output. One clock after the bit becomes 1, the output rises and the first high phase lasts W+1 ticks.
- R7: While bit n of the output-stage register (0x04) is 0, `pwm_out[n]` is 0. Bit 7+n of that register is stored only and does not affect the output.
- R8: While bit n of the tick-gate enable (0x0C) is 0, channel n receives no ticks and holds its level.
- R9: A write to the high or low count takes effect at the next LOW→HIGH boundary. The high phase that is running completes with its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, captured on the rising clock edge |
| addr | input | 8 | Byte address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_tick | input | 5 | Source clock tick enables, one per source |
| pwm_out | output | 7 | PWM outputs, channels 0..6 |

## Verification
Five sources tick with periods of 1 to 5 clocks. Every channel is swept over all sixteen combinations of high and low counts from 0 to 3. One channel is also run on every source, which separates a wrong source index from a wrong count and an off-by-one in the high phase from one in the low phase. Runtime writes land inside a running high phase to show whether the shadow counts isolate the current period. The same stimulus with the source removed, the tick gate cleared, or bypass selected distinguishes freezing from restarting, and counting from passing the tick through.

// File: rtl/whp_pkg.sv
package whp_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/whp_regfile.sv
module whp_regfile #(
    parameter int N_CH   = 7,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [N_CH-1:0][SEL_W-1:0]    sel_q,
    output logic [N_CH-1:0]               byp_q,
    output logic [N_CH-1:0]               oe_q,
    output logic [N_CH-1:0]               pre_q,
    output logic [N_CH-1:0]               post_q,
    output logic [N_CH-1:0][CNT_W-1:0]    wait_q,
    output logic [N_CH-1:0][CNT_W-1:0]    hold_q
);
    localparam int SELF_W  = SEL_W * N_CH;
    localparam int BYP_LSB = SELF_W;
    localparam int TM_LSB  = N_CH;
    localparam int WH_BASE = 16;
    localparam int WH_STEP = 8;
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_POST = ADDR_W'(12);

    logic [N_CH-1:0] tm_q;
    logic            unused_wbits;
    assign unused_wbits = ^wdata[DATA_W-1:BYP_LSB+N_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            byp_q  <= '0;
            oe_q   <= '0;
            tm_q   <= '0;
            pre_q  <= '0;
            post_q <= '0;
            wait_q <= '0;
            hold_q <= '0;
        end else if (wr_en) begin
            if (addr == A_SEL) begin
                sel_q <= wdata[SELF_W-1:0];
                byp_q <= wdata[BYP_LSB +: N_CH];
            end
            if (addr == A_OE) begin
                oe_q <= wdata[N_CH-1:0];
                tm_q <= wdata[TM_LSB +: N_CH];
            end
            if (addr == A_PRE)  pre_q  <= wdata[N_CH-1:0];
            if (addr == A_POST) post_q <= wdata[N_CH-1:0];
            for (int i = 0; i < N_CH; i++) begin
                if (addr == ADDR_W'(WH_BASE + WH_STEP*i))     wait_q[i] <= wdata[CNT_W-1:0];
                if (addr == ADDR_W'(WH_BASE + WH_STEP*i + 4)) hold_q[i] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_SEL) begin
            rdata[SELF_W-1:0]        = sel_q;
            rdata[BYP_LSB +: N_CH]   = byp_q;
        end
        if (addr == A_OE) begin
            rdata[N_CH-1:0]          = oe_q;
            rdata[TM_LSB +: N_CH]    = tm_q;
        end
        if (addr == A_PRE)  rdata[N_CH-1:0] = pre_q;
        if (addr == A_POST) rdata[N_CH-1:0] = post_q;
        for (int i = 0; i < N_CH; i++) begin
            if (addr == ADDR_W'(WH_BASE + WH_STEP*i))     rdata[CNT_W-1:0] = wait_q[i];
            if (addr == ADDR_W'(WH_BASE + WH_STEP*i + 4)) rdata[CNT_W-1:0] = hold_q[i];
        end
    end

    AST_OE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_OE) |-> (rdata[DATA_W-1:TM_LSB+N_CH] == '0)); // R2
    AST_REGS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sel_q) && $stable(oe_q) && $stable(pre_q) && $stable(post_q)
                    && $stable(wait_q) && $stable(hold_q))); // R2
endmodule

// File: rtl/whp_chan.sv
module whp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_en,
    input  logic             tick,
    input  logic             bypass,
    input  logic             oe,
    input  logic [CNT_W-1:0] wait_val,
    input  logic [CNT_W-1:0] hold_val,
    output logic             pwm
);
    import whp_pkg::*;

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] act_w_q, act_h_q;
    logic             load;
    logic             byp_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                state_d = CH_HIGH;
                cnt_d   = '0;
                load    = 1'b1;
            end
            CH_HIGH: begin
                if (tick) begin
                    if (cnt_q == act_w_q) begin
                        state_d = CH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CH_LOW: begin
                if (tick) begin
                    if (cnt_q == act_h_q) begin
                        state_d = CH_HIGH;
                        cnt_d   = '0;
                        load    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = CH_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (!pre_en) begin
            state_d = CH_IDLE;
            cnt_d   = '0;
            load    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            act_w_q <= '0;
            act_h_q <= '0;
            byp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            byp_q   <= tick;
            if (load) begin
                act_w_q <= wait_val;
                act_h_q <= hold_val;
            end
        end
    end

    always_comb begin
        pwm = 1'b0;
        if (oe) begin
            if (bypass) begin
                pwm = byp_q;
            end else begin
                unique case (state_q)
                    CH_HIGH: pwm = 1'b1;
                    CH_LOW:  pwm = 1'b0;
                    default: pwm = 1'b0;
                endcase
            end
        end
    end

    AST_IDLE_WHEN_PRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_en |=> (state_q == CH_IDLE)); // R6
    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && state_q == CH_IDLE) |=> (state_q == CH_HIGH && cnt_q == '0)); // R6
    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && state_q != CH_IDLE && !tick) |=> ($stable(cnt_q) && $stable(state_q))); // R4
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HIGH) |-> (cnt_q <= act_w_q)); // R3
    AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HIGH && $past(state_q) == CH_HIGH) |-> $stable(act_w_q)); // R9
endmodule

// File: rtl/wh_pwm_top.sv
module wh_pwm_top #(
    parameter int N_CH   = 7,
    parameter int N_SRC  = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_SRC-1:0]  src_tick,
    output logic [N_CH-1:0]   pwm_out
);
    localparam int SEL_W  = 3;
    localparam int SRC_IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_CH-1:0][SEL_W-1:0] sel_q;
    logic [N_CH-1:0]            byp_q, oe_q, pre_q, post_q;
    logic [N_CH-1:0][CNT_W-1:0] wait_q, hold_q;

    whp_regfile #(
        .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sel_q(sel_q), .byp_q(byp_q), .oe_q(oe_q), .pre_q(pre_q),
        .post_q(post_q), .wait_q(wait_q), .hold_q(hold_q)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [SEL_W-1:0] sel;
        logic             src_ok, hit, tick;
        assign sel    = sel_q[g];
        assign src_ok = (int'(sel) < N_SRC);
        assign hit    = src_ok ? src_tick[sel[SRC_IW-1:0]] : 1'b0;
        assign tick   = pre_q[g] & post_q[g] & hit;

        whp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .pre_en(pre_q[g]), .tick(tick),
            .bypass(byp_q[g]), .oe(oe_q[g]), .wait_val(wait_q[g]),
            .hold_val(hold_q[g]), .pwm(pwm_out[g])
        );
    end
endmodule

// File: tb/tb_wh_pwm_top.sv
module tb_wh_pwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  src_tick = '0;
    logic [6:0]  pwm_out;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    wh_pwm_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_tick(src_tick), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        for (int s = 0; s < 5; s++) src_tick[s] <= (((cyc + 1) % (s + 1)) == 0);
    end

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = 8'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        addr = 8'(a);
        #1 d = rdata;
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        int t = 0;
        hi = 0; lo = 0;
        while (pwm_out[ch] !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
        while (pwm_out[ch] !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
        while (pwm_out[ch] === 1'b1 && t < 4000) begin hi++; @(negedge clk); t++; end
        while (pwm_out[ch] === 1'b0 && t < 4000) begin lo++; @(negedge clk); t++; end
    endtask

    task automatic cfg(input int ch, input int sel, input int byp, input int w, input int h);
        bus_wr(8, 0);
        bus_wr(0, (32'(sel) << (3*ch)) | (32'(byp) << (21+ch)));
        bus_wr(16 + 8*ch, 32'(w));
        bus_wr(20 + 8*ch, 32'(h));
        bus_wr(8, 32'(1) << ch);
        bus_wr(12, 32'(1) << ch);
        bus_wr(4, 32'(1) << ch);
    endtask

    task automatic wait_high(input int ch);
        int t = 0;
        while (pwm_out[ch] !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
        while (pwm_out[ch] !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi, lo, run;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 72; a += 4) begin
            bus_rd(a, d);
            chk("R1 reset readback", d, 0);
        end
        chk("R1 outputs low", pwm_out, 0);

        // R2: readback masks and unmapped offsets
        @(negedge clk);
        bus_wr(0, 32'hFFFF_FFFF);  bus_rd(0, d);  chk("R2 select", d, 32'h0FFF_FFFF);
        @(negedge clk);
        bus_wr(4, 32'hFFFF_FFFF);  bus_rd(4, d);  chk("R2 output stage", d, 32'h0000_3FFF);
        @(negedge clk);
        bus_wr(8, 32'hFFFF_FFFF);  bus_rd(8, d);  chk("R2 count enable", d, 32'h7F);
        @(negedge clk);
        bus_wr(12, 32'hFFFF_FFFF); bus_rd(12, d); chk("R2 tick gate", d, 32'h7F);
        @(negedge clk);
        bus_wr(40, 32'hFFFF_FFFF); bus_rd(40, d); chk("R2 high count ch3", d, 32'hFFFF);
        @(negedge clk);
        bus_wr(20, 32'h0001_2345); bus_rd(20, d); chk("R2 low count ch0", d, 32'h2345);
        @(negedge clk);
        bus_wr(80, 32'hFFFF_FFFF); bus_rd(80, d); chk("R2 unmapped", d, 0);
        @(negedge clk);
        for (int a = 0; a < 72; a += 4) bus_wr(a, 0);

        // R3: sweep every channel over all small high/low counts
        for (int ch = 0; ch < 7; ch++) begin
            for (int w = 0; w < 4; w++) begin
                for (int h = 0; h < 4; h++) begin
                    int s = ch % 5;
                    cfg(ch, s, 0, w, h);
                    measure(ch, hi, lo);
                    chk($sformatf("R3 ch%0d w%0d h%0d high", ch, w, h), hi, (w+1)*(s+1));
                    chk($sformatf("R3 ch%0d w%0d h%0d low", ch, w, h), lo, (h+1)*(s+1));
                    chk("R7 other channels low", pwm_out & ~(7'(1) << ch), 0);
                end
            end
        end

        // R4: every valid source on channel 2
        for (int s = 0; s < 5; s++) begin
            cfg(2, s, 0, 1, 2);
            measure(2, hi, lo);
            chk($sformatf("R4 source %0d high", s), hi, 2*(s+1));
            chk($sformatf("R4 source %0d low", s), lo, 3*(s+1));
        end

        // R4: select codes 5..7 freeze the channel, valid code resumes
        for (int v = 5; v < 8; v++) begin
            cfg(3, 0, 0, 3, 3);
            wait_high(3);
            bus_wr(0, 32'(v) << 9);
            run = 0;
            for (int k = 0; k < 40; k++) begin
                if (pwm_out[3] === 1'b1) run++;
                @(negedge clk);
            end
            chk($sformatf("R4 code %0d frozen high", v), run, 40);
            bus_wr(0, 0);
            measure(3, hi, lo);
            chk("R4 resume high", hi, 4);
            chk("R4 resume low", lo, 4);
        end

        // R8: tick gate cleared holds level
        cfg(4, 1, 0, 2, 2);
        wait_high(4);
        bus_wr(12, 0);
        run = 0;
        for (int k = 0; k < 40; k++) begin
            if (pwm_out[4] === 1'b1) run++;
            @(negedge clk);
        end
        chk("R8 held high with gate off", run, 40);
        bus_wr(12, 32'h10);
        measure(4, hi, lo);
        chk("R8 resume high", hi, 6);
        chk("R8 resume low", lo, 6);

        // R5: bypass follows selected tick, counts ignored
        cfg(1, 2, 1, 3, 3);
        measure(1, hi, lo);
        chk("R5 bypass high", hi, 1);
        chk("R5 bypass low", lo, 2);
        cfg(1, 0, 1, 0, 3);
        repeat (3) @(negedge clk);
        run = 0;
        for (int k = 0; k < 20; k++) begin
            if (pwm_out[1] === 1'b1) run++;
            @(negedge clk);
        end
        chk("R5 bypass every-cycle source", run, 20);

        // R6: held idle while count stage off, restarts on high phase
        bus_wr(8, 0);
        bus_wr(0, 0);
        bus_wr(16, 3);
        bus_wr(20, 3);
        bus_wr(12, 1);
        bus_wr(4, 1);
        run = 0;
        for (int k = 0; k < 10; k++) begin
            if (pwm_out[0] !== 1'b0) run++;
            @(negedge clk);
        end
        chk("R6 idle output low", run, 0);
        bus_wr(8, 1);
        @(negedge clk);
        chk("R6 rises one clock after enable", pwm_out[0], 1);
        run = 0;
        while (pwm_out[0] === 1'b1 && run < 100) begin run++; @(negedge clk); end
        chk("R6 first high phase length", run, 4);

        // R7: output stage off drives low, transfer-mode bit has no effect
        bus_wr(4, 32'h80);
        run = 0;
        for (int k = 0; k < 30; k++) begin
            if (pwm_out[0] !== 1'b0) run++;
            @(negedge clk);
        end
        chk("R7 output stage off", run, 0);
        bus_wr(4, 32'h81);
        measure(0, hi, lo);
        chk("R7 transfer bit keeps high", hi, 4);
        chk("R7 transfer bit keeps low", lo, 4);

        // R9: count write during a high phase waits for the period boundary
        wait_high(0);
        run = 1;
        bus_wr(16, 0);
        while (pwm_out[0] === 1'b1 && run < 100) begin run++; @(negedge clk); end
        chk("R9 running high keeps old length", run, 4);
        measure(0, hi, lo);
        chk("R9 next high uses new count", hi, 1);
        chk("R9 low unchanged", lo, 4);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule